// File: doc/BRIEF.md
# Vector Word Inequality Compare Unit

This unit compares two 128-bit vector operands one 32-bit word at a time. Each word lane is tested for inequality on its own. The unit returns a 128-bit mask in which a lane is filled with ones when its two words differ and with zeros when they match. It also builds a four-bit condition nibble that summarises the lanes: one flag means every lane differed and another means no lane differed. Both results come out of a single register stage, one clock after the request.

An execution pipeline issues a request with a valid strobe. Along with the strobe it supplies a record flag, which asks for the condition nibble to be written, and a vector-facility enable. When the facility is disabled, the unit does not compare. Instead it raises a one-cycle unavailable fault and asserts neither write enable.

Top module: `vec_ne_cmp`

## Requirements
- R1: A word lane i (bits 32*i+31 down to 32*i, lanes 0 to 3) whose operand words differ yields 32'hFFFF_FFFF in lane i of `res_mask`.
- R2: A word lane whose operand words are equal yields 32'h0000_0000 in that lane of `res_mask`.
- R3: `cond_nib` is {every_lane_differs, 1'b0, no_lane_differs, 1'b0}, bit 3 first. Identical operands give 4'b0010, operands that differ in all four lanes give 4'b1000, and a mix of equal and unequal lanes gives 4'b0000.
- R4: `cond_we` is high only for a request with `rec_en`=1. With `rec_en`=0 it stays low and `cond_nib` reads 4'b0000, while the mask is still written.
- R5: A request with `vec_on`=0 sets `unavail_fault` and keeps `res_we` and `cond_we` low, with `res_mask` and `cond_nib` at zero.
- R6: All outputs appear exactly one clock after the valid strobe and last for that one cycle only. Back-to-back requests give back-to-back results.
- R7: The synchronous active-high `rst` clears every output to zero.
- R8: In a cycle that carries no result, `res_mask`, `cond_nib`, `res_we`, `cond_we` and `unavail_fault` all read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| opnd_a | input | 128 | First vector operand |
| opnd_b | input | 128 | Second vector operand |
| rec_en | input | 1 | Request a write of the condition nibble |
| vec_on | input | 1 | Vector facility enabled |
| res_mask | output | 128 | Per-lane inequality mask |
| res_we | output | 1 | Write enable for the mask |
| cond_nib | output | 4 | Condition summary nibble |
| cond_we | output | 1 | Write enable for the nibble |
| unavail_fault | output | 1 | Vector-unavailable fault pulse |

## Verification
The assertions run on every cycle and check these properties:
- A fault and a mask write never happen in the same cycle.
- A nibble write only comes with a mask write.
- The two padding bits of the nibble are always zero.
- Every written lane is uniform, either all ones or all zeros.
- Each accepted or faulted request produces its pulse exactly one cycle later.
- The mask matches the lane comparison of the previous cycle's operands.

Some behaviour only the bench scenarios can show:
- The exact summary value for identical, fully different and mixed operands.
- That `rec_en`=0 suppresses the nibble while the mask is still written.
- That a disabled facility leaves nothing written, including across back-to-back requests and idle gaps.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

    localparam int LANES   = 4;
    localparam int LANE_W  = 32;
    localparam int VEC_W   = LANES * LANE_W;
    localparam int NIB_W   = 4;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [VEC_W-1:0]  vec_t;
    typedef logic [LANES-1:0]  lane_flags_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef struct packed {
        logic all_ne;
        logic none_ne;
    } summary_t;

    typedef struct packed {
        vec_t mask;
        nib_t nib;
        logic res_we;
        logic cond_we;
        logic fault;
    } cmp_result_t;

    localparam cmp_result_t RESULT_IDLE = '{default: '0};

    function automatic lane_t lane_fill(input logic ne);
        return ne ? {LANE_W{1'b1}} : {LANE_W{1'b0}};
    endfunction

    // Summary layout: every-lane-differs, pad, no-lane-differs, pad
    function automatic nib_t pack_summary(input summary_t s);
        return {s.all_ne, 1'b0, s.none_ne, 1'b0};
    endfunction

endpackage

// File: rtl/vcmp_lane.sv
module vcmp_lane
    import vcmp_pkg::*;
(
    input  lane_t a_word,
    input  lane_t b_word,
    output logic  ne,
    output lane_t fill
);
    always_comb begin
        ne   = (a_word != b_word);
        fill = lane_fill(ne);
    end
endmodule

// File: rtl/vcmp_reduce.sv
module vcmp_reduce
    import vcmp_pkg::*;
(
    input  lane_flags_t lane_ne,
    output summary_t    summ,
    output nib_t        nib
);
    always_comb begin
        summ.all_ne  = &lane_ne;
        summ.none_ne = ~|lane_ne;
        nib          = pack_summary(summ);
    end
endmodule

// File: rtl/vcmp_outreg.sv
module vcmp_outreg
    import vcmp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        rec_en,
    input  logic        vec_on,
    input  vec_t        mask_d,
    input  nib_t        nib_d,
    output cmp_result_t q
);
    cmp_result_t d;
    logic        fire;

    always_comb begin
        fire      = in_valid && vec_on;
        d         = RESULT_IDLE;
        d.fault   = in_valid && !vec_on;
        if (fire) begin
            d.mask   = mask_d;
            d.res_we = 1'b1;
            if (rec_en) begin
                d.nib     = nib_d;
                d.cond_we = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= RESULT_IDLE;
        else     q <= d;
    end
endmodule

// File: rtl/vec_ne_cmp.sv
module vec_ne_cmp
    import vcmp_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] opnd_a,
    input  logic [127:0] opnd_b,
    input  logic         rec_en,
    input  logic         vec_on,
    output logic [127:0] res_mask,
    output logic         res_we,
    output logic [3:0]   cond_nib,
    output logic         cond_we,
    output logic         unavail_fault
);
    lane_flags_t lane_ne;
    vec_t        mask_c;
    summary_t    summ;
    nib_t        nib_c;
    cmp_result_t r_q;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vcmp_lane u_lane (
            .a_word (opnd_a[i*LANE_W +: LANE_W]),
            .b_word (opnd_b[i*LANE_W +: LANE_W]),
            .ne     (lane_ne[i]),
            .fill   (mask_c[i*LANE_W +: LANE_W])
        );
    end

    vcmp_reduce u_reduce (
        .lane_ne (lane_ne),
        .summ    (summ),
        .nib     (nib_c)
    );

    vcmp_outreg u_outreg (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .rec_en   (rec_en),
        .vec_on   (vec_on),
        .mask_d   (mask_c),
        .nib_d    (nib_c),
        .q        (r_q)
    );

    assign res_mask      = r_q.mask;
    assign res_we        = r_q.res_we;
    assign cond_nib      = r_q.nib;
    assign cond_we       = r_q.cond_we;
    assign unavail_fault = r_q.fault;
endmodule

// File: rtl/vec_ne_cmp_chk.sv
module vec_ne_cmp_chk (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [127:0] opnd_a,
    input logic [127:0] opnd_b,
    input logic         rec_en,
    input logic         vec_on,
    input logic [127:0] res_mask,
    input logic         res_we,
    input logic [3:0]   cond_nib,
    input logic         cond_we,
    input logic         unavail_fault
);
    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    function automatic logic lanes_uniform(input logic [127:0] m);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < 4; i++)
            if (m[i*32 +: 32] != '0 && m[i*32 +: 32] != '1) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [127:0] ne_mask(input logic [127:0] a, input logic [127:0] b);
        logic [127:0] m;
        for (int i = 0; i < 4; i++)
            m[i*32 +: 32] = (a[i*32 +: 32] != b[i*32 +: 32]) ? '1 : '0;
        return m;
    endfunction

    // R5
    fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(unavail_fault && (res_we || cond_we)));

    // R4
    cond_needs_res_chk: assert property (@(posedge clk) disable iff (rst)
        cond_we |-> res_we);

    // R3
    pad_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cond_nib[2] == 1'b0 && cond_nib[0] == 1'b0);

    // R1
    lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        res_we |-> lanes_uniform(res_mask));

    // R6
    write_latency_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (res_we == ($past(in_valid) && $past(vec_on))));

    // R5
    fault_latency_chk: assert property (@(posedge clk) disable iff (rst)
        armed |-> (unavail_fault == ($past(in_valid) && !$past(vec_on))));

    // R2
    mask_value_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && res_we) |-> res_mask == ne_mask($past(opnd_a), $past(opnd_b)));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !res_we |-> (res_mask == '0 && cond_nib == '0));
endmodule

bind vec_ne_cmp vec_ne_cmp_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .rec_en(rec_en), .vec_on(vec_on), .res_mask(res_mask), .res_we(res_we),
    .cond_nib(cond_nib), .cond_we(cond_we), .unavail_fault(unavail_fault)
);

// File: tb/vec_ne_cmp_bench.sv
module vec_ne_cmp_bench;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] opnd_a = '0;
    logic [127:0] opnd_b = '0;
    logic         rec_en = 1'b0;
    logic         vec_on = 1'b0;
    logic [127:0] res_mask;
    logic         res_we;
    logic [3:0]   cond_nib;
    logic         cond_we;
    logic         unavail_fault;

    typedef struct {
        logic [127:0] mask;
        logic [3:0]   nib;
        logic         we;
        logic         cwe;
        logic         flt;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   drv_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_ne_cmp u_vec_ne_cmp (
        .clk(clk), .rst(rst), .in_valid(in_valid), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .rec_en(rec_en), .vec_on(vec_on), .res_mask(res_mask), .res_we(res_we),
        .cond_nib(cond_nib), .cond_we(cond_we), .unavail_fault(unavail_fault)
    );

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic v, input logic [127:0] a, input logic [127:0] b,
                                   input logic rc, input logic en, input string tag);
        exp_t e;
        int   nd;
        e.mask = '0; e.nib = '0; e.we = 1'b0; e.cwe = 1'b0; e.flt = 1'b0; e.tag = tag;
        if (v && !en) e.flt = 1'b1;
        if (v && en) begin
            nd = 0;
            for (int i = 0; i < 4; i++) begin
                if (a[i*32 +: 32] != b[i*32 +: 32]) begin
                    e.mask[i*32 +: 32] = 32'hFFFF_FFFF;
                    nd++;
                end
            end
            e.we = 1'b1;
            if (rc) begin
                e.cwe = 1'b1;
                e.nib = {(nd == 4), 1'b0, (nd == 0), 1'b0};
            end
        end
        return e;
    endfunction

    task automatic drive(input logic v, input logic [127:0] a, input logic [127:0] b,
                         input logic rc, input logic en, input string tag);
        @(negedge clk);
        in_valid = v; opnd_a = a; opnd_b = b; rec_en = rc; vec_on = en;
        exp_q.push_back(model(v, a, b, rc, en, tag));
    endtask

    // Monitor: one expected item per cycle after the edge that registers it
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check({"R1 R2 mask ", e.tag}, res_mask, e.mask);
                check({"R3 nibble ", e.tag}, {124'd0, cond_nib}, {124'd0, e.nib});
                check({"R6 res_we ", e.tag}, {127'd0, res_we}, {127'd0, e.we});
                check({"R4 cond_we ", e.tag}, {127'd0, cond_we}, {127'd0, e.cwe});
                check({"R5 fault ", e.tag}, {127'd0, unavail_fault}, {127'd0, e.flt});
            end
        end
    end

    initial begin
        logic [127:0] x;
        x = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
        repeat (3) @(negedge clk);
        // R7: outputs during reset
        check("R7 reset mask", res_mask, '0);
        check("R7 reset flags", {123'd0, res_we, cond_nib, cond_we, unavail_fault} , '0);
        // drive a request during reset: must not show afterwards
        in_valid = 1'b1; vec_on = 1'b1; rec_en = 1'b1; opnd_a = '1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        check("R7 after reset", {123'd0, res_we, cond_nib, cond_we, unavail_fault}, '0);

        drive(1, x, x, 1, 1, "identical (R3 0010)");
        drive(1, x, ~x, 1, 1, "all differ (R3 1000)");
        drive(1, x, x ^ 128'h1_0000_0000_0000_0000, 1, 1, "mixed lane2 (R3 0000)");
        drive(1, x, x ^ 128'h8000_0000_0000_0000_0000_0000_0000_0001, 1, 1, "lanes 0,3 (R1)");
        drive(0, x, ~x, 1, 1, "idle (R8)");
        drive(1, x, ~x, 1, 0, "disabled (R5)");
        drive(1, x, x, 1, 0, "disabled equal (R5)");
        drive(1, x, ~x, 0, 1, "no record (R4)");
        drive(1, '0, '0, 0, 1, "zero no record (R2 R4)");
        drive(0, '0, '1, 0, 0, "idle 2 (R8)");
        for (int k = 0; k < 40; k++) begin
            logic [127:0] a, b;
            a = {$urandom, $urandom, $urandom, $urandom};
            b = a;
            for (int l = 0; l < 4; l++)
                if ($urandom_range(0, 1) == 1) b[l*32 +: 32] = a[l*32 +: 32] ^ (32'd1 << (k % 32));
            drive($urandom_range(0, 3) != 0, a, b, $urandom_range(0, 1) == 1,
                  $urandom_range(0, 4) != 0, "mixed traffic (R6)");
        end
        drive(0, '0, '0, 0, 0, "drain (R8)");
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        drv_done = 1'b1;
    end

    initial begin
        fork
            wait (drv_done && exp_q.size() == 0);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule